// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit unsigned operands and an incoming carry, producing a 16-bit sum and a carry out of the top bit. It is purely combinational. Results appear on the outputs in the same cycle as the inputs, with no registers on the way.

The operands are split into four slices of four bits each. Inside a slice, every bit position forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each internal carry is then written as a flat sum of products of those terms and the carry entering the slice.

Each slice also summarises itself as one slice-generate term and one slice-propagate term. A second lookahead stage applies the same flat equations to these four summaries. That stage yields the carries into bits 4, 8 and 12 and the final carry out, all directly from the carry-in. No carry ever travels serially from one slice to the next.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, the 17-bit value {carry_out, sum_out} equals op_a + op_b + carry_in taken as unsigned numbers.
- R2: For k = 1, 2, 3, the carry entering bit 4k equals bit 4 of the sum of the low 4k operand bits plus carry_in. That carry is observable at the ports as sum_out[4k] XOR op_a[4k] XOR op_b[4k].
- R3: A slice in which some bit has both operand bits set, and every higher bit of that slice propagates, passes a 1 into the next slice regardless of carry_in. Example: op_a = op_b = 0x0008 gives a carry into bit 4 for carry_in of 0 and of 1.
- R4: When every bit position propagates but none generates (op_a OR op_b = 0xFFFF, op_a AND op_b = 0), carry_out equals carry_in and sum_out equals 0xFFFF + carry_in modulo 2^16.
- R5: A carry travels across all four slices. 0xFFFF + 0x0001 with carry_in 0 gives sum_out 0x0000 and carry_out 1. 0xFFFF + 0xFFFF with carry_in 1 gives sum_out 0xFFFF and carry_out 1.
- R6: Zero operands with carry_in 0 give sum_out 0x0000 and carry_out 0. Zero operands with carry_in 1 give sum_out 0x0001 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to bring about from the ports is a carry born in the lowest slice that must pass through three slices, each of which only propagates. Random operands almost never line up that way. The stimulus therefore builds such patterns deliberately. It uses all-ones plus one, and complementary operand pairs such as 0xAAAA with 0x5555 under both carry-in values. It also places a single generating bit at the top of a slice, so the carry into the next slice can be read back through that slice's lowest sum bit.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Summary of a slice for the second lookahead stage
  typedef struct packed {
    logic gen;
    logic prop;
  } slice_gp_t;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry_o,
  output logic         blk_gen_o,
  output logic         blk_prop_o
);

  // Every carry is a flat sum of products; no carry feeds another carry.
  always_comb begin
    carry_o[0] = cin;
    for (int i = 0; i < N; i++) begin
      logic term;
      logic prod;
      term = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = gen_i[j];
        for (int k = j + 1; k <= i; k++) prod = prod & prop_i[k];
        term = term | prod;
      end
      prod = cin;
      for (int k = 0; k <= i; k++) prod = prod & prop_i[k];
      carry_o[i+1] = term | prod;
    end
  end

  always_comb begin
    logic term;
    logic prod;
    term = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = gen_i[j];
      for (int k = j + 1; k < N; k++) prod = prod & prop_i[k];
      term = term | prod;
    end
    blk_gen_o  = term;
    blk_prop_o = &prop_i;
  end

  // R3: the block summary must agree with the top carry built from bit terms
  always_comb begin
    a_r3_block_summary: assert (carry_o[N] == (blk_gen_o | (blk_prop_o & cin)))
      else $error("R3 block summary disagrees with top carry");
  end

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin,
  output logic [GW-1:0] sum_o,
  output slice_gp_t     gp_o
);

  logic [GW-1:0] bit_gen;
  logic [GW-1:0] bit_prop;
  logic [GW:0]   carry;
  logic          blk_gen;
  logic          blk_prop;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i | b_i;

  cla_lookahead #(.N(GW)) u_la (
    .gen_i     (bit_gen),
    .prop_i    (bit_prop),
    .cin       (cin),
    .carry_o   (carry),
    .blk_gen_o (blk_gen),
    .blk_prop_o(blk_prop)
  );

  assign sum_o   = a_i ^ b_i ^ carry[GW-1:0];
  assign gp_o.gen  = blk_gen;
  assign gp_o.prop = blk_prop;

  // R2: the slice on its own behaves as a GW-bit adder with carry
  always_comb begin
    a_r2_slice_add: assert ({carry[GW], sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{GW{1'b0}}, cin}))
      else $error("R2 slice sum mismatch");
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int GROUP_W  = 4,
  parameter int N_GROUPS = 4,
  localparam int WIDTH   = GROUP_W * N_GROUPS
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  slice_gp_t [N_GROUPS-1:0] slice_gp;
  logic [N_GROUPS-1:0]      slice_gen;
  logic [N_GROUPS-1:0]      slice_prop;
  logic [N_GROUPS:0]        slice_carry;
  logic                     all_gen;
  logic                     all_prop;

  for (genvar g = 0; g < N_GROUPS; g++) begin : gen_slice
    cla_group #(.GW(GROUP_W)) u_slice (
      .a_i  (op_a[g*GROUP_W +: GROUP_W]),
      .b_i  (op_b[g*GROUP_W +: GROUP_W]),
      .cin  (slice_carry[g]),
      .sum_o(sum_out[g*GROUP_W +: GROUP_W]),
      .gp_o (slice_gp[g])
    );
    assign slice_gen[g]  = slice_gp[g].gen;
    assign slice_prop[g] = slice_gp[g].prop;
  end

  // Second level: slice carries straight from carry_in and slice summaries
  cla_lookahead #(.N(N_GROUPS)) u_top_la (
    .gen_i     (slice_gen),
    .prop_i    (slice_prop),
    .cin       (carry_in),
    .carry_o   (slice_carry),
    .blk_gen_o (all_gen),
    .blk_prop_o(all_prop)
  );

  assign carry_out = slice_carry[N_GROUPS];

  always_comb begin
    // R1: full-width result matches arithmetic sum
    a_r1_full_sum: assert ({carry_out, sum_out} ==
                           ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("R1 full sum mismatch");
    // R4: a word that propagates everywhere passes carry_in straight through
    a_r4_pass_through: assert (!(all_prop && !all_gen) || (carry_out == carry_in))
      else $error("R4 pass-through carry mismatch");
    // R3: a generating word produces a carry out whatever carry_in is
    a_r3_word_gen: assert (!all_gen || carry_out)
      else $error("R3 generated carry missing");
  end

endmodule

// File: tb/cla_adder16_test.sv
module cla_adder16_test;

  logic        clk;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic        carry_in;
  logic [15:0] sum_out;
  logic        carry_out;

  int n_checks = 0;
  int n_fail   = 0;

  cla_adder16 uut (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(posedge clk);
    #1;
  endtask

  task automatic check_full(input string tag, input logic [15:0] a,
                            input logic [15:0] b, input logic c);
    logic [16:0] exp;
    apply(a, b, c);
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    n_checks++;
    if ({carry_out, sum_out} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h c=%0d actual=%h expected=%h",
               tag, a, b, c, {carry_out, sum_out}, exp);
    end
  endtask

  task automatic check_bound(input logic [15:0] a, input logic [15:0] b, input logic c);
    apply(a, b, c);
    for (int k = 1; k < 4; k++) begin
      logic [16:0] low;
      logic        exp_c;
      logic        act_c;
      low   = ({1'b0, a} & ((17'd1 << (4*k)) - 1)) +
              ({1'b0, b} & ((17'd1 << (4*k)) - 1)) + {16'd0, c};
      exp_c = low[4*k];
      act_c = sum_out[4*k] ^ a[4*k] ^ b[4*k];
      n_checks++;
      if (act_c !== exp_c) begin
        n_fail++;
        $display("FAIL R2 carry into bit %0d a=%h b=%h c=%0d actual=%0d expected=%0d",
                 4*k, a, b, c, act_c, exp_c);
      end
    end
  endtask

  // R6: all-zero operands
  task automatic t_zero;
    check_full("R6", 16'h0000, 16'h0000, 1'b0);
    check_full("R6", 16'h0000, 16'h0000, 1'b1);
  endtask

  // R5: carry through all four slices
  task automatic t_wrap;
    check_full("R5", 16'hFFFF, 16'h0001, 1'b0);
    check_full("R5", 16'hFFFF, 16'hFFFF, 1'b1);
    check_full("R5", 16'h0001, 16'hFFFF, 1'b0);
  endtask

  // R4: propagate-only words pass carry_in to carry_out
  task automatic t_propagate;
    check_full("R4", 16'hFFFF, 16'h0000, 1'b0);
    check_full("R4", 16'hFFFF, 16'h0000, 1'b1);
    check_full("R4", 16'hAAAA, 16'h5555, 1'b0);
    check_full("R4", 16'hAAAA, 16'h5555, 1'b1);
    check_full("R4", 16'h0F0F, 16'hF0F0, 1'b1);
  endtask

  // R3: a generating top bit in each slice forces the next slice's carry
  task automatic t_generate;
    for (int s = 0; s < 3; s++) begin
      logic [15:0] v;
      v = 16'h0008 << (4*s);
      check_bound(v, v, 1'b0);
      check_bound(v, v, 1'b1);
      n_checks++;
      if (sum_out[4*s+4] !== 1'b1) begin
        n_fail++;
        $display("FAIL R3 slice %0d actual=%0d expected=1", s, sum_out[4*s+4]);
      end
    end
    check_full("R3", 16'h8000, 16'h8000, 1'b0);
  endtask

  // R2: slice boundaries under varied patterns
  task automatic t_bounds;
    check_bound(16'h000F, 16'h0001, 1'b0);
    check_bound(16'h0FFF, 16'h0000, 1'b1);
    check_bound(16'h1A33, 16'hE5EB, 1'b0);
    for (int i = 0; i < 100; i++)
      check_bound(16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  // R1: random operands
  task automatic t_random;
    for (int i = 0; i < 400; i++)
      check_full("R1", 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  initial begin
    op_a = '0; op_b = '0; carry_in = 1'b0;
    repeat (2) @(posedge clk);
    t_zero();
    t_wrap();
    t_propagate();
    t_generate();
    t_bounds();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule